// File: doc/BRIEF.md
# Streaming Row Tag Allocator

This block sits in front of a deeply pipelined reduction datapath. Values stream in at most one per cycle. Each value carries a marker that flags the final value of its row. The block attaches a small row tag to every value and detects where each row begins. It hands out tags in a fixed round-robin sequence. For every tag it measures how long ago the closing value of its row entered. When that hold time has elapsed, the block announces that the row's result may be taken from the result store and that the tag is available again.

The hold time is H = 2·D + D·⌈log2 D⌉ + 1 cycles, where D is the depth of the downstream operator pipeline. Tags are reissued in strict rotation and every row is held for the same H cycles. Completion strobes therefore come out in the same order in which the rows arrived.

The tag count defaults to the number needed for a guaranteed minimum row length M, which is ⌈(H + M − 1)/M⌉. Any other value may be given instead. If a row starts while its tag is still held, the block flags the clash and allocates the tag anyway.

There is no back-pressure on either side. The input has no ready signal, and every cycle with `in_valid` high is accepted. The tagged output carries a valid strobe only, and the consumer must take every beat. The done strobe is a plain pulse.

Top module: `rtag_alloc`

## Requirements
- R1: While reset is held, `out_valid`, `out_err` and `done_valid` are low. The first row after reset receives tag 0.
- R2: Each accepted beat appears on the output exactly one cycle later, with the same data and last flag. A cycle with `in_valid` low produces a cycle with `out_valid` low.
- R3: A row starts with the first accepted beat after reset or after a beat with `in_last` high, and `out_first` marks that beat. Every beat of one row carries the same tag.
- R4: Successive rows receive tags 0, 1, …, TAGS−1, and the sequence then wraps to 0.
- R5: `done_valid` pulses with `done_tag` equal to the row's tag exactly H cycles after the output cycle of the row's last beat. With D = 4, H = 17.
- R6: A tag is free again in the cycle its done strobe appears. A row starting in that cycle takes the tag without error, and both events are visible together.
- R7: `out_err` is high on a row's first beat if that beat's tag is still held by an earlier row whose strobe has not yet appeared. Allocation and timing still proceed: the new row restarts the hold for that tag.
- R8: With TAGS left at its default, M = 1 gives TAGS = H and M ≥ H gives TAGS = 2.
- R9: At most one done strobe is raised per cycle.
- R10: Idle input cycles do not advance the tag sequence. The hold timers count every clock cycle, whether or not input is arriving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present (always accepted) |
| in_data | input | DATA_W | Input value |
| in_last | input | 1 | Beat closes its row |
| out_valid | output | 1 | Tagged beat present |
| out_data | output | DATA_W | Value passed through |
| out_tag | output | TAG_W | Row tag of the beat |
| out_first | output | 1 | Beat opens a row |
| out_last | output | 1 | Beat closes its row |
| out_err | output | 1 | Opening beat reused a still-held tag |
| done_valid | output | 1 | A row's hold time has elapsed |
| done_tag | output | TAG_W | Tag of the completed row |

## Verification
The bench builds three copies with D = 4, so H = 17, and drives them with one shared stimulus.

The first copy keeps the default of 17 tags. A burst of one-beat rows, which is the worst case, then runs through the full rotation and reaches exact same-cycle reuse without a clash.

The second copy is forced to 16 tags, so the same burst brings the clash flag into reach. The third copy sets the minimum row length to 17, which yields two tags. Long rows cycle cleanly through that copy, while short rows make it clash.

// File: rtl/rtag_pkg.sv
package rtag_pkg;

  // Cycles a tag stays held after its row's closing beat enters.
  function automatic int unsigned hold_cycles(input int unsigned depth);
    return 2 * depth + depth * $clog2(depth) + 1;
  endfunction

  // Tags needed so that rotation never meets a held tag, for rows of at
  // least min_len beats: ceil((hold + min_len - 1) / min_len).
  function automatic int unsigned tags_for(input int unsigned hold,
                                           input int unsigned min_len);
    return (hold + 2 * min_len - 2) / min_len;
  endfunction

endpackage

// File: rtl/rtag_issuer.sv
module rtag_issuer #(
  parameter int unsigned TAGS  = 17,
  parameter int unsigned TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  output logic [TAG_W-1:0] beat_tag,
  output logic             beat_first
);

  localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(TAGS - 1);

  logic             row_open;
  logic [TAG_W-1:0] next_tag;
  logic [TAG_W-1:0] cur_tag;

  assign beat_first = !row_open;
  assign beat_tag   = row_open ? cur_tag : next_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open <= 1'b0;
      next_tag <= '0;
      cur_tag  <= '0;
    end else if (in_valid) begin
      if (!row_open) begin
        cur_tag  <= next_tag;
        next_tag <= (next_tag == LAST_TAG) ? '0 : next_tag + 1'b1;
      end
      row_open <= !in_last;
    end
  end

  p_tag_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> beat_tag <= LAST_TAG);

  p_row_continues_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_last) |=> !beat_first);

  p_row_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> beat_first);

endmodule

// File: rtl/rtag_timer.sv
module rtag_timer #(
  parameter int unsigned HOLD  = 17,
  parameter int unsigned CNT_W = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic free,
  output logic expire
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(HOLD);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign expire = busy_q && (cnt_q == ONE);
  assign free   = !busy_q || expire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      cnt_q  <= FULL;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == ONE) busy_q <= 1'b0;
    end
  end

  p_load_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && cnt_q == FULL));

  p_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0 && cnt_q <= FULL));

  p_expire_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !busy_q);

endmodule

// File: rtl/rtag_alloc.sv
module rtag_alloc #(
  parameter int unsigned DEPTH       = 4,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned MIN_ROW_LEN = 1,
  parameter int unsigned TAGS        =
    rtag_pkg::tags_for(rtag_pkg::hold_cycles(DEPTH), MIN_ROW_LEN),
  parameter int unsigned TAG_W       = (TAGS > 1) ? $clog2(TAGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [TAG_W-1:0]  out_tag,
  output logic              out_first,
  output logic              out_last,
  output logic              out_err,
  output logic              done_valid,
  output logic [TAG_W-1:0]  done_tag
);

  localparam int unsigned HOLD  = rtag_pkg::hold_cycles(DEPTH);
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic [TAG_W-1:0] beat_tag;
  logic             beat_first;
  logic [TAGS-1:0]  load_vec;
  logic [TAGS-1:0]  free_vec;
  logic [TAGS-1:0]  expire_vec;
  logic [TAG_W-1:0] expire_tag;
  logic             clash;

  rtag_issuer #(.TAGS(TAGS), .TAG_W(TAG_W)) u_issuer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .beat_tag   (beat_tag),
    .beat_first (beat_first)
  );

  for (genvar t = 0; t < TAGS; t++) begin : g_timer
    assign load_vec[t] = in_valid && in_last && (beat_tag == TAG_W'(t));
    rtag_timer #(.HOLD(HOLD), .CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load_vec[t]),
      .free   (free_vec[t]),
      .expire (expire_vec[t])
    );
  end

  always_comb begin
    expire_tag = '0;
    for (int t = 0; t < TAGS; t++) begin
      if (expire_vec[t]) expire_tag = TAG_W'(t);
    end
  end

  assign clash = in_valid && beat_first && !free_vec[beat_tag];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_tag    <= '0;
      out_first  <= 1'b0;
      out_last   <= 1'b0;
      out_err    <= 1'b0;
      done_valid <= 1'b0;
      done_tag   <= '0;
    end else begin
      out_valid  <= in_valid;
      out_data   <= in_data;
      out_tag    <= beat_tag;
      out_first  <= beat_first;
      out_last   <= in_last;
      out_err    <= clash;
      done_valid <= |expire_vec;
      done_tag   <= expire_tag;
    end
  end

  p_one_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(expire_vec));

  p_beat_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_data == $past(in_data)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_err));

  p_err_on_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_valid && out_first));

endmodule

// File: tb/rtag_alloc_bench.sv
module rtag_alloc_bench;

  localparam int HOLD = 17;
  localparam int NI   = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic        in_last;

  logic        ov   [NI];
  logic [15:0] od   [NI];
  logic        ofst [NI];
  logic        olst [NI];
  logic        oerr [NI];
  logic        dv   [NI];
  logic [4:0]  tag_a, dtag_a;
  logic [3:0]  tag_b, dtag_b;
  logic [0:0]  tag_c, dtag_c;

  rtag_alloc u_rtag_alloc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .out_valid(ov[0]), .out_data(od[0]), .out_tag(tag_a),
    .out_first(ofst[0]), .out_last(olst[0]), .out_err(oerr[0]),
    .done_valid(dv[0]), .done_tag(dtag_a));

  rtag_alloc #(.TAGS(16)) u_rtag_alloc_short (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .out_valid(ov[1]), .out_data(od[1]), .out_tag(tag_b),
    .out_first(ofst[1]), .out_last(olst[1]), .out_err(oerr[1]),
    .done_valid(dv[1]), .done_tag(dtag_b));

  rtag_alloc #(.MIN_ROW_LEN(17)) u_rtag_alloc_long (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .out_valid(ov[2]), .out_data(od[2]), .out_tag(tag_c),
    .out_first(ofst[2]), .out_last(olst[2]), .out_err(oerr[2]),
    .done_valid(dv[2]), .done_tag(dtag_c));

  int vectors = 0;
  int misses  = 0;
  bit finished = 0;

  // Reference state: tag count, rotation pointer, open row, release edges.
  int ntags [NI] = '{17, 16, 2};
  int nxt   [NI];
  int cur   [NI];
  bit open  [NI];
  int rel   [NI][32];
  int edge_n;

  task automatic check(input int inst, input string req, input int act,
                       input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s inst%0d edge %0d: actual %0d expected %0d",
               req, inst, edge_n, act, exp);
    end
  endtask

  function automatic int act_tag(input int i);
    case (i)
      0: return int'(tag_a);
      1: return int'(tag_b);
      default: return int'(tag_c);
    endcase
  endfunction

  function automatic int act_dtag(input int i);
    case (i)
      0: return int'(dtag_a);
      1: return int'(dtag_b);
      default: return int'(dtag_c);
    endcase
  endfunction

  task automatic cycle(input bit v, input bit l, input logic [15:0] d);
    bit e_dv [NI];
    int e_dt [NI];
    bit e_f  [NI];
    int e_t  [NI];
    bit e_er [NI];
    in_valid = v;
    in_last  = l;
    in_data  = d;
    @(posedge clk);
    edge_n++;
    for (int i = 0; i < NI; i++) begin
      e_dv[i] = 0;
      e_dt[i] = 0;
      for (int t = 0; t < ntags[i]; t++)
        if (rel[i][t] == edge_n) begin
          e_dv[i] = 1;
          e_dt[i] = t;
        end
      if (v) begin
        e_f[i]  = !open[i];
        e_t[i]  = e_f[i] ? nxt[i] : cur[i];
        e_er[i] = e_f[i] && (rel[i][e_t[i]] > edge_n);
        if (e_f[i]) begin
          cur[i] = nxt[i];
          nxt[i] = (nxt[i] + 1) % ntags[i];
        end
        open[i] = !l;
        if (l) rel[i][e_t[i]] = edge_n + HOLD;
      end
    end
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check(i, "R2 valid (R10 idle)", int'(ov[i]), int'(v));
      if (v) begin
        check(i, "R2 data", int'(od[i]), int'(d));
        check(i, "R2 last", int'(olst[i]), int'(l));
        check(i, "R3 first", int'(ofst[i]), int'(e_f[i]));
        check(i, (i == 2) ? "R3 R4 R8 tag" : "R3 R4 tag", act_tag(i), e_t[i]);
        check(i, "R7 clash", int'(oerr[i]), int'(e_er[i]));
      end
      // R9 single strobe and R10 timers across idle cycles are covered here.
      check(i, "R5 done strobe", int'(dv[i]), int'(e_dv[i]));
      if (e_dv[i]) check(i, "R5 R6 done tag", act_dtag(i), e_dt[i]);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    edge_n = 0;
    for (int i = 0; i < NI; i++) begin
      nxt[i] = 0;
      cur[i] = 0;
      open[i] = 0;
      for (int t = 0; t < 32; t++) rel[i][t] = 0;
    end
    rst_n = 0;
    in_valid = 1;
    in_last = 1;
    in_data = 16'h1234;
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      check(i, "R1 reset out_valid", int'(ov[i]), 0);
      check(i, "R1 reset out_err", int'(oerr[i]), 0);
      check(i, "R1 reset done_valid", int'(dv[i]), 0);
    end
    rst_n = 1;

    // Worst case: one-beat rows back to back, past a full rotation (R6).
    for (int k = 0; k < 45; k++) cycle(1, 1, 16'(16'h0100 + k));
    // Drain with idle cycles.
    for (int k = 0; k < 25; k++) cycle(0, 0, 16'h0);
    // Long rows that suit the two-tag copy.
    for (int r = 0; r < 6; r++)
      for (int k = 0; k < 20; k++) cycle(1, k == 19, 16'(r * 256 + k));
    for (int k = 0; k < 25; k++) cycle(0, 0, 16'h0);
    // Mixed traffic with gaps.
    for (int k = 0; k < 400; k++)
      cycle(($urandom % 4) != 0, ($urandom % 3) == 0, 16'($urandom));
    for (int k = 0; k < 25; k++) cycle(0, 0, 16'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule